// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies streamed activation rows by a weight matrix held inside a square grid of multiply-accumulate cells. A weight matrix B is shifted into the grid one row per cycle through a dedicated port. It then stays resident, and cell (k,j) keeps B[k][j]. Each activation row A is presented in a single cycle together with an optional addend row C. The block skews the row elements onto the left edge of the grid, one cycle per row index. Each activation moves one cell to the right per cycle. Partial sums move one cell down per cycle, and the top row of cells starts from C. The bottom edge yields one row of D = A·B + C. Output registers align the N column results, so a whole row leaves in one cycle under a single valid strobe.

Rows may arrive on every cycle, and any number of them can be streamed against one loaded weight set. A small controller guards the weights. It is a three-state machine: IDLE (no rows in flight, no load this cycle), LOAD (a weight row was taken this cycle) and FLOW (activation rows in flight). An accepted row moves the controller from IDLE or LOAD to FLOW and reloads its drain counter. A load request with no row present moves it from IDLE or FLOW-drained to LOAD. FLOW returns to IDLE when the drain counter runs out with no new row. Weight shifting is permitted only outside FLOW and only when no row is presented in the same cycle.

Top module: `ws_matmul`

## Requirements
- R1: After reset, res_valid and res_row are 0 and every weight cell holds 0, so the first row streamed before any load returns exactly its C row.
- R2: Each accepted load puts wt_row into the top cell row and moves every cell row down one place. Element j of wt_row (bits [j*8 +: 8]) goes to column j. After N accepted loads presented in the order B[N-1], ..., B[1], B[0], cell row k holds B[k].
- R3: Column j of res_row (bits [j*32 +: 32]) equals C[j] + sum over k of A[k]*B[k][j]. A[k] is act_row bits [k*8 +: 8] and C[j] is bias_row bits [j*32 +: 32]. All values are signed two's complement, and the sum wraps at 32 bits.
- R4: A row accepted at a clock edge has res_valid high, with all N columns valid, exactly 2N-1 = 7 clock edges later, counting that accepting edge as the first.
- R5: Rows may be accepted on consecutive cycles. Their results leave on consecutive cycles in the same order.
- R6: A loaded weight set stays unchanged over any number of streamed rows and over idle cycles.
- R7: A wt_load in the same cycle as act_valid is ignored.
- R8: A wt_load presented in any of the 2N-2 = 6 cycles after the cycle that presented an accepted row is ignored. From the 7th such cycle on, it is accepted.
- R9: res_valid is low in every cycle that is not 7 edges after an accepted row.
- R10: Extreme operands are computed exactly. Examples are -128 times -128 summed over all rows, and 127 times -128 added to a large C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wt_load | input | 1 | Request to shift one weight row into the grid |
| wt_row | input | N*8 | Weight row, column j at bits [j*8 +: 8] |
| act_valid | input | 1 | An activation row is presented this cycle |
| act_row | input | N*8 | Activation row, element k at bits [k*8 +: 8] |
| bias_row | input | N*32 | Addend row C, column j at bits [j*32 +: 32] |
| res_valid | output | 1 | res_row holds a finished row |
| res_row | output | N*32 | Result row, column j at bits [j*32 +: 32] |

## Verification
Two functions can meet in one cycle: a weight shift and an activation row, either presented together or with the row still in the grid. The bench provokes this in two ways. It raises wt_load together with act_valid. It also raises wt_load six cycles after a row and then seven cycles after it, straddling the drain boundary. The outcome is judged at the ports, not inside the grid. Rows streamed afterwards must match a product built from the weights the bench's own model says are loaded, and any forbidden shift would show up as a wrong result.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_FLOW = 2'd2
    } ws_state_e;
endpackage

// File: rtl/ws_delay.sv
module ws_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/ws_cell.sv
module ws_cell #(
    parameter int AW = 8,
    parameter int SW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_en,
    input  logic signed [AW-1:0] w_in,
    input  logic signed [AW-1:0] a_in,
    input  logic signed [SW-1:0] ps_in,
    output logic signed [AW-1:0] w_q,
    output logic signed [AW-1:0] a_q,
    output logic signed [SW-1:0] ps_q
);
    logic signed [2*AW-1:0] prod;
    assign prod = a_in * w_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q  <= '0;
            a_q  <= '0;
            ps_q <= '0;
        end else begin
            if (w_en) w_q <= w_in;
            a_q  <= a_in;
            ps_q <= ps_in + SW'(prod);
        end
    end
endmodule

// File: rtl/ws_ctrl.sv
module ws_ctrl
    import ws_pkg::*;
#(
    parameter int LAT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_valid,
    input  logic wt_load,
    output logic w_shift
);
    localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;

    ws_state_e       st, st_nx;
    logic [CW-1:0]   cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = ST_IDLE;
        cnt_nx = cnt;
        unique case (st)
            ST_IDLE, ST_LOAD: begin
                if (act_valid) begin
                    st_nx  = ST_FLOW;
                    cnt_nx = CW'(LAT - 1);
                end else if (wt_load) begin
                    st_nx = ST_LOAD;
                end
            end
            ST_FLOW: begin
                if (act_valid) begin
                    st_nx  = ST_FLOW;
                    cnt_nx = CW'(LAT - 1);
                end else begin
                    cnt_nx = cnt - CW'(1);
                    st_nx  = (cnt > CW'(1)) ? ST_FLOW : ST_IDLE;
                end
            end
            default: begin
                st_nx  = ST_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    always_comb begin
        w_shift = 1'b0;
        unique case (st)
            ST_IDLE, ST_LOAD: w_shift = wt_load && !act_valid;
            ST_FLOW:          w_shift = 1'b0;
            default:          w_shift = 1'b0;
        endcase
    end
endmodule

// File: rtl/ws_matmul.sv
module ws_matmul #(
    parameter int N  = 4,
    parameter int AW = 8,
    parameter int SW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_load,
    input  logic [N*AW-1:0]   wt_row,
    input  logic              act_valid,
    input  logic [N*AW-1:0]   act_row,
    input  logic [N*SW-1:0]   bias_row,
    output logic              res_valid,
    output logic [N*SW-1:0]   res_row
);
    localparam int LAT = 2 * N - 1;

    logic                 w_shift;
    logic signed [AW-1:0] a_h  [N][N+1];
    logic signed [SW-1:0] ps_v [N+1][N];
    logic signed [AW-1:0] w_v  [N][N];
    logic [N*N*AW-1:0]    w_flat;

    ws_ctrl #(.LAT(LAT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_valid (act_valid),
        .wt_load   (wt_load),
        .w_shift   (w_shift)
    );

    ws_delay #(.W(1), .DEPTH(LAT)) u_vpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (act_valid),
        .q     (res_valid)
    );

    generate
        for (genvar j = 0; j < N; j++) begin : g_edge
            ws_delay #(.W(SW), .DEPTH(j)) u_bias (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (bias_row[j*SW +: SW]),
                .q     (ps_v[0][j])
            );
            ws_delay #(.W(SW), .DEPTH(N-1-j)) u_align (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (ps_v[N][j]),
                .q     (res_row[j*SW +: SW])
            );
        end

        for (genvar k = 0; k < N; k++) begin : g_row
            logic unused_tail;
            assign unused_tail = ^a_h[k][N];

            ws_delay #(.W(AW), .DEPTH(k)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (act_row[k*AW +: AW]),
                .q     (a_h[k][0])
            );

            for (genvar j = 0; j < N; j++) begin : g_col
                logic signed [AW-1:0] w_src;
                if (k == 0) begin : g_top
                    assign w_src = wt_row[j*AW +: AW];
                end else begin : g_below
                    assign w_src = w_v[k-1][j];
                end

                ws_cell #(.AW(AW), .SW(SW)) u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .w_en  (w_shift),
                    .w_in  (w_src),
                    .a_in  (a_h[k][j]),
                    .ps_in (ps_v[k][j]),
                    .w_q   (w_v[k][j]),
                    .a_q   (a_h[k][j+1]),
                    .ps_q  (ps_v[k+1][j])
                );

                assign w_flat[(k*N+j)*AW +: AW] = w_v[k][j];
            end
        end
    endgenerate
endmodule

// File: rtl/ws_matmul_chk.sv
module ws_matmul_chk #(
    parameter int N  = 4,
    parameter int AW = 8,
    parameter int SW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wt_load,
    input logic [N*AW-1:0]   wt_row,
    input logic              act_valid,
    input logic              res_valid,
    input logic              w_shift,
    input logic [N*N*AW-1:0] w_flat
);
    localparam int LAT = 2 * N - 1;

    logic [LAT-1:0] vsh;
    int             fly;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsh <= '0;
            fly <= 0;
        end else begin
            vsh <= {vsh[LAT-2:0], act_valid};
            if (act_valid)    fly <= LAT - 1;
            else if (fly > 0) fly <= fly - 1;
        end
    end

    // R1: outputs quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !res_valid);

    // R2: an accepted shift lands the input row in the top cells
    a_r2_top_row_load: assert property (@(posedge clk) disable iff (!rst_n)
        w_shift |=> (w_flat[N*AW-1:0] == $past(wt_row)));

    // R4 / R9: valid strobe follows accepted rows by exactly LAT edges
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == vsh[LAT-1]);

    // R7: a presented row freezes the weights at that edge
    a_r7_act_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> $stable(w_flat));

    // R8: rows still in the grid freeze the weights
    a_r8_flight_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
        (fly != 0) |=> $stable(w_flat));

    // R8: with the grid drained and no row, a request is taken
    a_r8_drained_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (fly == 0 && wt_load && !act_valid) |-> w_shift);
endmodule

bind ws_matmul ws_matmul_chk #(.N(N), .AW(AW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wt_load   (wt_load),
    .wt_row    (wt_row),
    .act_valid (act_valid),
    .res_valid (res_valid),
    .w_shift   (w_shift),
    .w_flat    (w_flat)
);

// File: tb/sim_ws_matmul.sv
module sim_ws_matmul;
    localparam int N   = 4;
    localparam int AW  = 8;
    localparam int SW  = 32;
    localparam int LAT = 2 * N - 1;
    localparam int NV  = 8;

    localparam int TB_B [N][N] = '{
        '{  3, -2,   7,  1},
        '{ -5,  4,   0,  9},
        '{ 12, -1,  -8,  2},
        '{  6, 11,  -3, -4}};
    localparam int TV_A [NV][N] = '{
        '{  1,   2,   3,   4},
        '{ -1,  -2,  -3,  -4},
        '{  0,   0,   0,   0},
        '{127,   0,   0,   0},
        '{  0,-128,   0,   0},
        '{ 10, -20,  30, -40},
        '{ 99,  55, -77,  13},
        '{  5,   5,   5,   5}};
    localparam int TV_C [NV][N] = '{
        '{0, 0, 0, 0},
        '{100, -100, 0, 7},
        '{-1, 2, -3, 4},
        '{0, 0, 0, 0},
        '{1000, 2000, 3000, 4000},
        '{0, 0, 0, 0},
        '{-50000, 50000, 1, -1},
        '{0, 0, 0, 0}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wt_load = 1'b0;
    logic [N*AW-1:0]   wt_row = '0;
    logic              act_valid = 1'b0;
    logic [N*AW-1:0]   act_row = '0;
    logic [N*SW-1:0]   bias_row = '0;
    logic              res_valid;
    logic [N*SW-1:0]   res_row;

    always #4 clk = ~clk;

    ws_matmul #(.N(N), .AW(AW), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_row(wt_row),
        .act_valid(act_valid), .act_row(act_row), .bias_row(bias_row),
        .res_valid(res_valid), .res_row(res_row)
    );

    int             n_chk = 0;
    int             n_bad = 0;
    int             cyc = 0;
    int             last_act = -100;
    bit             mon_en = 1'b0;
    bit             done = 1'b0;
    string          tag = "R1";
    logic           exp_v [16];
    logic [N*SW-1:0] exp_r [16];
    int             tb_w [N][N];
    int unsigned    lfsr = 32'h1234_abcd;
    int             bset [N][N];

    always @(negedge clk) begin : mon
        int s;
        cyc++;
        s = cyc % 16;
        if (mon_en) begin
            n_chk++;
            if (res_valid !== exp_v[s]) begin
                n_bad++;
                $display("FAIL %s R4 R9 cycle %0d res_valid=%b expected %b", tag, cyc, res_valid, exp_v[s]);
            end else if (exp_v[s] && res_row !== exp_r[s]) begin
                n_bad++;
                $display("FAIL %s R3 cycle %0d res_row=%h expected %h", tag, cyc, res_row, exp_r[s]);
            end
        end
        exp_v[s] = 1'b0;
    end

    function automatic int unsigned next_rand(input int unsigned x);
        int unsigned y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic drive(input bit av, input logic [N*AW-1:0] ar, input logic [N*SW-1:0] br,
                         input bit wl, input logic [N*AW-1:0] wr);
        logic [N*SW-1:0] ex;
        int s;
        @(negedge clk);
        #1;
        act_valid = av; act_row = ar; bias_row = br; wt_load = wl; wt_row = wr;
        if (av) begin
            for (int j = 0; j < N; j++) begin
                s = $signed(br[j*SW +: SW]);
                for (int k = 0; k < N; k++) s += $signed(ar[k*AW +: AW]) * tb_w[k][j];
                ex[j*SW +: SW] = s;
            end
            exp_v[(cyc + LAT) % 16] = 1'b1;
            exp_r[(cyc + LAT) % 16] = ex;
            last_act = cyc;
        end else if (wl && cyc >= last_act + LAT) begin
            for (int k = N - 1; k > 0; k--)
                for (int j = 0; j < N; j++) tb_w[k][j] = tb_w[k-1][j];
            for (int j = 0; j < N; j++) tb_w[0][j] = $signed(wr[j*AW +: AW]);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0, '0);
    endtask

    task automatic load_set();
        logic [N*AW-1:0] wr;
        for (int r = N - 1; r >= 0; r--) begin
            for (int j = 0; j < N; j++) wr[j*AW +: AW] = AW'(bset[r][j]);
            drive(1'b0, '0, '0, 1'b1, wr);
        end
    endtask

    task automatic rand_row(output logic [N*AW-1:0] ar, output logic [N*SW-1:0] br);
        for (int k = 0; k < N; k++) begin
            lfsr = next_rand(lfsr);
            ar[k*AW +: AW] = lfsr[AW-1:0];
            lfsr = next_rand(lfsr);
            br[k*SW +: SW] = lfsr;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        mon_en = 1'b0;
        rst_n = 1'b0;
        act_valid = 1'b0; wt_load = 1'b0;
        for (int i = 0; i < 16; i++) exp_v[i] = 1'b0;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) tb_w[k][j] = 0;
        last_act = -100;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        n_chk++;
        if (res_valid !== 1'b0 || res_row !== '0) begin
            n_bad++;
            $display("FAIL R1 after reset res_valid=%b res_row=%h expected 0 and 0", res_valid, res_row);
        end
        mon_en = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N*AW-1:0] ar;
        logic [N*SW-1:0] br;
        logic [N*AW-1:0] wr;

        for (int i = 0; i < 16; i++) exp_v[i] = 1'b0;

        // R1: reset state; zero weights pass C through
        tag = "R1";
        do_reset();
        rand_row(ar, br);
        drive(1'b1, ar, br, 1'b0, '0);
        idle(LAT + 1);

        // R2 R3 R5: load table weights, stream the vector table back to back
        tag = "R2 R3 R5";
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) bset[k][j] = TB_B[k][j];
        load_set();
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < N; k++) ar[k*AW +: AW] = AW'(TV_A[v][k]);
            for (int j = 0; j < N; j++) br[j*SW +: SW] = SW'(TV_C[v][j]);
            drive(1'b1, ar, br, 1'b0, '0);
        end
        idle(LAT + 1);

        // R6 R9: random rows with random gaps, same weights
        tag = "R6 R9";
        for (int i = 0; i < 40; i++) begin
            rand_row(ar, br);
            lfsr = next_rand(lfsr);
            drive(lfsr[0] | lfsr[1], ar, br, 1'b0, '0);
        end
        idle(LAT + 1);

        // R7: load requested in the same cycle as a row
        tag = "R7";
        rand_row(ar, br);
        drive(1'b1, ar, br, 1'b1, 32'h7f80_55aa);
        idle(LAT + 2);
        for (int i = 0; i < 6; i++) begin
            rand_row(ar, br);
            drive(1'b1, ar, br, 1'b0, '0);
        end
        idle(LAT + 1);

        // R8: load six cycles after a row is ignored, seven cycles after is taken
        tag = "R8";
        rand_row(ar, br);
        drive(1'b1, ar, br, 1'b0, '0);
        idle(LAT - 2);
        drive(1'b0, '0, '0, 1'b1, 32'h0102_0304);
        drive(1'b0, '0, '0, 1'b1, 32'hfdfe_ff05);
        for (int i = 0; i < 6; i++) begin
            rand_row(ar, br);
            drive(1'b1, ar, br, 1'b0, '0);
        end
        idle(LAT + 1);

        // R10: extreme operands
        tag = "R10";
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++) bset[k][j] = (j == 3) ? 127 : -128;
        load_set();
        drive(1'b1, {N{8'h80}}, '0, 1'b0, '0);
        drive(1'b1, {N{8'h80}}, {N{32'h7fff_0000}}, 1'b0, '0);
        drive(1'b1, {N{8'h7f}}, {N{32'h8000_0000}}, 1'b0, '0);
        idle(LAT + 1);

        // R1: reset with rows in flight clears outputs and weights
        tag = "R1";
        rand_row(ar, br);
        drive(1'b1, ar, br, 1'b0, '0);
        drive(1'b1, ar, br, 1'b0, '0);
        do_reset();
        wr = '0;
        rand_row(ar, br);
        drive(1'b1, ar, br, 1'b0, wr);
        idle(LAT + 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule